// File: doc/BRIEF.md
# Command-Driven Persistent Reduction Accumulator

This block holds one signed running accumulator that streamed reduce instructions update. Each instruction starts with a one-cycle start pulse that carries a command code, an output mode, a pre-operation with its scalar, a fold operation and a seed immediate. The elements of the instruction then arrive on an element stream, and the last one is flagged. Every element is first combined with the scalar, and the result is then folded into the accumulator. The block can report only the final value (collapse mode) or the running value after every element (cumulative mode).

The accumulator keeps its value between instructions. A continue command can therefore chain one reduction across several tiles. The seeding commands restart it from zero, from the fold identity or from an immediate. A separate read-back request returns the stored value once, with or without a sign flip, and leaves the stored value as it was.

Top module: `acc_reduce`

## Requirements
- R1: After reset the accumulator is 0, and `resValid` and `rdValid` are low.
- R2: Command 3 (zero-accumulate) seeds the identity and then folds each element as acc = acc fold (x pre scalar). The identity is 0 for add and 0x80000000 for max. Pre codes: 0 x+scalar, 1 x-scalar, 2 low 32 bits of x*scalar, 3 x. Fold codes: 0 wrapping add, 1 signed max.
- R3: Command 4 (load-accumulate) seeds the accumulator from `instrSeed` and then folds as in R2.
- R4: Command 2 (accumulate) folds onto the value that the previous instruction left.
- R5: Command 1 (zero) clears the accumulator and consumes no elements. Command 0 (idle) and codes 5 to 7 leave it untouched. Elements that arrive outside an active fold instruction are ignored and produce no result.
- R6: In collapse mode (`instrCumulative`=0) an instruction produces exactly one result, the final value, one cycle after its last element.
- R7: In cumulative mode every accepted element produces a result one cycle later, equal to the running value that includes that element.
- R8: A read request gives `rdValid` one cycle later, with the current accumulator on `rdData`. The stored value does not change.
- R9: With `rdNeg`=1 the read returns the negated value and the stored value is kept. Negating 0x80000000 gives 0x7FFFFFFF.
- R10: A start pulse while an instruction is still receiving elements is ignored.
- R11: The accumulator holds its value over any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrStart | input | 1 | Starts an instruction |
| instrCmd | input | 3 | Command code |
| instrCumulative | input | 1 | 1 = cumulative, 0 = collapse |
| instrPreOp | input | 2 | Element pre-operation |
| instrFoldOp | input | 1 | Fold operation |
| instrScalar | input | DATA_W | Pre-operation scalar |
| instrSeed | input | DATA_W | Seed for load-accumulate |
| elemValid | input | 1 | Element present |
| elemData | input | DATA_W | Element value |
| elemLast | input | 1 | Last element of the instruction |
| resValid | output | 1 | Result present |
| resData | output | DATA_W | Result value |
| rdReq | input | 1 | Read-back request |
| rdNeg | input | 1 | Negate the read-back value |
| rdValid | output | 1 | Read-back value present |
| rdData | output | DATA_W | Read-back value |

## Verification
A wrong accumulator state shows at the ports in two places. In cumulative mode it shows on the very next result, one cycle after the element. In collapse mode it shows only in the final result, or on the next read-back, which answers one cycle after the request. For that reason every instruction is followed by a read-back, so a corrupted seed, a lost chain value or a clear that should not have happened becomes visible before the next instruction begins. Negated reads are followed by plain reads, which shows that the stored value was not written back.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE       = 3'd0,
    CMD_ZERO       = 3'd1,
    CMD_ACCUM      = 3'd2,
    CMD_ZERO_ACCUM = 3'd3,
    CMD_LOAD_ACCUM = 3'd4
  } accCmd_e;

  typedef enum logic [1:0] {
    PRE_ADD  = 2'd0,
    PRE_SUB  = 2'd1,
    PRE_MUL  = 2'd2,
    PRE_PASS = 2'd3
  } preOp_e;

  typedef enum logic {
    FOLD_ADD = 1'b0,
    FOLD_MAX = 1'b1
  } foldOp_e;

  typedef enum logic [1:0] {
    SEED_ZERO  = 2'd0,
    SEED_IDENT = 2'd1,
    SEED_IMM   = 2'd2
  } seedSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchOps;
    logic     seedLoad;
    seedSel_e seedSel;
    logic     foldEn;
    logic     emitRes;
    logic     rdEn;
    logic     rdNeg;
  } accStrobe_t;

endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrStart,
  input  logic [2:0] instrCmd,
  input  logic       instrCumulative,
  input  logic       elemValid,
  input  logic       elemLast,
  input  logic       rdReq,
  input  logic       rdNeg,
  output accStrobe_t str
);

  logic activeQ;
  logic cumQ;
  logic startOk;

  assign startOk = instrStart && !activeQ;

  always_comb begin
    str          = '0;
    str.seedSel  = SEED_ZERO;
    str.rdEn     = rdReq;
    str.rdNeg    = rdNeg;
    if (startOk) begin
      unique case (instrCmd)
        CMD_ZERO: begin
          str.seedLoad = 1'b1;
          str.seedSel  = SEED_ZERO;
        end
        CMD_ZERO_ACCUM: begin
          str.seedLoad = 1'b1;
          str.seedSel  = SEED_IDENT;
          str.latchOps = 1'b1;
        end
        CMD_LOAD_ACCUM: begin
          str.seedLoad = 1'b1;
          str.seedSel  = SEED_IMM;
          str.latchOps = 1'b1;
        end
        CMD_ACCUM: str.latchOps = 1'b1;
        default: ;
      endcase
    end
    str.foldEn  = activeQ && elemValid;
    str.emitRes = activeQ && elemValid && (cumQ || elemLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      cumQ    <= 1'b0;
    end else if (str.latchOps) begin
      activeQ <= 1'b1;
      cumQ    <= instrCumulative;
    end else if (activeQ && elemValid && elemLast) begin
      activeQ <= 1'b0;
    end
  end

  // an instruction closes on its last element
  p_close_on_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    activeQ && elemValid && elemLast |=> !activeQ);

  // a start pulse while active keeps the instruction open
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    activeQ && instrStart && !(elemValid && elemLast) |=> activeQ);

endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        str,
  input  logic [1:0]        instrPreOp,
  input  logic              instrFoldOp,
  input  logic [DATA_W-1:0] instrScalar,
  input  logic [DATA_W-1:0] instrSeed,
  input  logic [DATA_W-1:0] elemData,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] scalarQ;
  preOp_e            preQ;
  foldOp_e           foldQ;
  logic [DATA_W-1:0] preRes;
  logic [DATA_W-1:0] foldRes;
  logic [DATA_W-1:0] seedVal;
  logic [DATA_W-1:0] negVal;

  always_comb begin
    unique case (preQ)
      PRE_ADD: preRes = elemData + scalarQ;
      PRE_SUB: preRes = elemData - scalarQ;
      PRE_MUL: preRes = elemData * scalarQ;
      default: preRes = elemData;
    endcase
  end

  always_comb begin
    if (foldQ == FOLD_MAX)
      foldRes = ($signed(preRes) > $signed(accQ)) ? preRes : accQ;
    else
      foldRes = accQ + preRes;
  end

  always_comb begin
    unique case (str.seedSel)
      SEED_IDENT: seedVal = (instrFoldOp == FOLD_MAX) ? MIN_V : '0;
      SEED_IMM:   seedVal = instrSeed;
      default:    seedVal = '0;
    endcase
  end

  assign negVal = (accQ == MIN_V) ? MAX_V : (~accQ + 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ    <= '0;
      scalarQ <= '0;
      preQ    <= PRE_PASS;
      foldQ   <= FOLD_ADD;
    end else begin
      if (str.latchOps) begin
        scalarQ <= instrScalar;
        preQ    <= preOp_e'(instrPreOp);
        foldQ   <= foldOp_e'(instrFoldOp);
      end
      if (str.seedLoad)    accQ <= seedVal;
      else if (str.foldEn) accQ <= foldRes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resData  <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
    end else begin
      resValid <= str.emitRes;
      if (str.emitRes) resData <= foldRes;
      rdValid <= str.rdEn;
      if (str.rdEn) rdData <= str.rdNeg ? negVal : accQ;
    end
  end

  // reading never disturbs the stored value
  p_read_keeps_acc_r8: assert property (@(posedge clk) disable iff (!rstN)
    str.rdEn && !str.seedLoad && !str.foldEn |=> accQ == $past(accQ));

  // negating the most negative value saturates
  p_neg_sat_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && $past(str.rdNeg) && ($past(accQ) == MIN_V) |-> rdData == MAX_V);

endmodule

// File: rtl/acc_reduce.sv
module acc_reduce
  import acc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrStart,
  input  logic [2:0]        instrCmd,
  input  logic              instrCumulative,
  input  logic [1:0]        instrPreOp,
  input  logic              instrFoldOp,
  input  logic [DATA_W-1:0] instrScalar,
  input  logic [DATA_W-1:0] instrSeed,
  input  logic              elemValid,
  input  logic [DATA_W-1:0] elemData,
  input  logic              elemLast,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  input  logic              rdReq,
  input  logic              rdNeg,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  accStrobe_t str;

  acc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .instrStart(instrStart), .instrCmd(instrCmd),
    .instrCumulative(instrCumulative),
    .elemValid(elemValid), .elemLast(elemLast),
    .rdReq(rdReq), .rdNeg(rdNeg),
    .str(str)
  );

  acc_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .str(str),
    .instrPreOp(instrPreOp), .instrFoldOp(instrFoldOp),
    .instrScalar(instrScalar), .instrSeed(instrSeed),
    .elemData(elemData),
    .resValid(resValid), .resData(resData),
    .rdValid(rdValid), .rdData(rdData)
  );

  // a result only follows an element on the stream
  p_res_after_elem_r7: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(elemValid));

endmodule

// File: tb/acc_reduce_tb.sv
module acc_reduce_tb;

  localparam int W = 32;
  localparam logic [W-1:0] MINV = 32'h8000_0000;
  localparam logic [W-1:0] MAXV = 32'h7FFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrStart = 0, instrCumulative = 0, instrFoldOp = 0;
  logic [2:0] instrCmd = 0;
  logic [1:0] instrPreOp = 0;
  logic [W-1:0] instrScalar = 0, instrSeed = 0, elemData = 0;
  logic elemValid = 0, elemLast = 0, rdReq = 0, rdNeg = 0;
  logic resValid, rdValid;
  logic [W-1:0] resData, rdData;

  always #2 clk = ~clk;  // 250 MHz

  acc_reduce #(.DATA_W(W)) u_dut (.*);

  typedef struct packed {
    logic [2:0]   cmd;
    logic         cum;
    logic [1:0]   pre;
    logic         fold;
    logic [W-1:0] scalar;
    logic [W-1:0] seed;
    logic [W-1:0] e0, e1, e2, e3;
    logic [W-1:0] expFinal;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd3, 1'b0, 2'd0, 1'b0, 32'd1,     32'd0,   32'd1,  32'd2,   32'd3,      32'd4,        32'd14},
    '{3'd2, 1'b1, 2'd3, 1'b0, 32'd0,     32'd0,   32'd10, 32'd20,  32'd30,     32'd40,       32'd114},
    '{3'd4, 1'b0, 2'd1, 1'b1, 32'd5,     32'd100, 32'd50, 32'd200, 32'(-10),   32'd105,      32'd195},
    '{3'd3, 1'b1, 2'd2, 1'b1, 32'(-2),   32'd0,   32'd3,  32'(-4), 32'd1,      32'(-7),      32'd14},
    '{3'd2, 1'b0, 2'd2, 1'b0, 32'd3,     32'd0,   32'd1,  32'd1,   32'd1,      32'd1,        32'd26},
    '{3'd3, 1'b1, 2'd3, 1'b1, 32'd0,     32'd0,   32'(-5), 32'(-9), 32'(-3),   32'(-100),    32'(-3)}
  };

  int nChecks = 0, nFails = 0;
  logic [W-1:0] mAcc = 0;
  logic mCum = 0;
  logic [1:0] mPre = 0;
  logic mFold = 0;
  logic [W-1:0] mScalar = 0;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] modelStep(input logic [W-1:0] x);
    logic [W-1:0] t;
    case (mPre)
      2'd0: t = x + mScalar;
      2'd1: t = x - mScalar;
      2'd2: t = x * mScalar;
      default: t = x;
    endcase
    if (mFold) return ($signed(t) > $signed(mAcc)) ? t : mAcc;
    return mAcc + t;
  endfunction

  task automatic startInstr(input logic [2:0] cmd, input logic cum, input logic [1:0] pre,
                            input logic fold, input logic [W-1:0] sc, input logic [W-1:0] sd);
    @(negedge clk);
    instrStart = 1; instrCmd = cmd; instrCumulative = cum; instrPreOp = pre;
    instrFoldOp = fold; instrScalar = sc; instrSeed = sd;
    @(negedge clk);
    instrStart = 0;
  endtask

  // send one element; report result one cycle later
  task automatic sendElem(input logic [W-1:0] x, input logic last,
                          output logic gotV, output logic [W-1:0] gotD);
    @(negedge clk);
    elemValid = 1; elemData = x; elemLast = last;
    @(negedge clk);
    elemValid = 0; elemLast = 0;
    gotV = resValid; gotD = resData;
  endtask

  task automatic readAcc(input logic neg, output logic v, output logic [W-1:0] d);
    @(negedge clk);
    rdReq = 1; rdNeg = neg;
    @(negedge clk);
    rdReq = 0; rdNeg = 0;
    v = rdValid; d = rdData;
  endtask

  task automatic runVec(input vec_t v);
    logic [W-1:0] el [4];
    logic gv, rv;
    logic [W-1:0] gd, rd;
    el[0] = v.e0; el[1] = v.e1; el[2] = v.e2; el[3] = v.e3;
    mCum = v.cum; mPre = v.pre; mFold = v.fold; mScalar = v.scalar;
    if (v.cmd == 3'd3) mAcc = v.fold ? MINV : '0;
    else if (v.cmd == 3'd4) mAcc = v.seed;
    startInstr(v.cmd, v.cum, v.pre, v.fold, v.scalar, v.seed);
    for (int i = 0; i < 4; i++) begin
      mAcc = modelStep(el[i]);
      sendElem(el[i], i == 3, gv, gd);
      if (v.cum) begin
        check("R7 cumulative valid", {31'd0, gv}, 32'd1);
        check("R7 cumulative value", gd, mAcc);
      end else if (i < 3) begin
        check("R6 collapse silent", {31'd0, gv}, 32'd0);
      end else begin
        check("R6 collapse valid", {31'd0, gv}, 32'd1);
        check("R6 collapse value", gd, v.expFinal);
      end
    end
    check("R2 R3 R4 model final", mAcc, v.expFinal);
    readAcc(1'b0, rv, rd);
    check("R8 read valid", {31'd0, rv}, 32'd1);
    check("R8 read value after R2 R3 R4", rd, v.expFinal);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic v;
    logic [W-1:0] d;
    repeat (3) @(negedge clk);
    check("R1 resValid reset", {31'd0, resValid}, 32'd0);
    check("R1 rdValid reset", {31'd0, rdValid}, 32'd0);
    rstN = 1;
    readAcc(1'b0, v, d);
    check("R1 acc reset", d, 32'd0);

    for (int k = 0; k < 6; k++) runVec(VECS[k]);

    // R9 negate keeps stored value
    readAcc(1'b1, v, d);
    check("R9 negated read", d, 32'd3);
    readAcc(1'b0, v, d);
    check("R9 stored unchanged", d, 32'(-3));

    // R5 idle command: elements ignored
    startInstr(3'd0, 1'b1, 2'd3, 1'b0, 0, 0);
    sendElem(32'd7, 1'b0, v, d);
    check("R5 idle no result", {31'd0, v}, 32'd0);
    sendElem(32'd7, 1'b1, v, d);
    check("R5 idle no result last", {31'd0, v}, 32'd0);
    readAcc(1'b0, v, d);
    check("R5 idle untouched", d, 32'(-3));

    // R5 reserved code 5
    startInstr(3'd5, 1'b1, 2'd3, 1'b0, 0, 32'd99);
    sendElem(32'd8, 1'b1, v, d);
    check("R5 code5 no result", {31'd0, v}, 32'd0);
    readAcc(1'b0, v, d);
    check("R5 code5 untouched", d, 32'(-3));

    // R11 hold over idle cycles
    repeat (50) @(negedge clk);
    readAcc(1'b0, v, d);
    check("R11 hold", d, 32'(-3));

    // R5 zero clears without consuming
    startInstr(3'd1, 1'b1, 2'd3, 1'b0, 0, 0);
    sendElem(32'd9, 1'b1, v, d);
    check("R5 zero no result", {31'd0, v}, 32'd0);
    readAcc(1'b0, v, d);
    check("R5 zero clears", d, 32'd0);

    // R10 restart ignored while active
    startInstr(3'd3, 1'b0, 2'd3, 1'b0, 0, 0);
    sendElem(32'd5, 1'b0, v, d);
    startInstr(3'd1, 1'b0, 2'd3, 1'b0, 0, 0);
    sendElem(32'd6, 1'b1, v, d);
    check("R10 valid", {31'd0, v}, 32'd1);
    check("R10 restart ignored", d, 32'd11);
    readAcc(1'b0, v, d);
    check("R10 read", d, 32'd11);

    // R9 saturation with R3 seed
    startInstr(3'd4, 1'b0, 2'd3, 1'b1, 0, MINV);
    sendElem(MINV, 1'b1, v, d);
    check("R3 min seed result", d, MINV);
    readAcc(1'b1, v, d);
    check("R9 saturate", d, MAXV);
    readAcc(1'b0, v, d);
    check("R9 stored min", d, MINV);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule